// File: doc/BRIEF.md
# XGMII Transmit Framer with Lane-0 Gap Alignment

This block takes frames as a stream of 32-bit words, four bytes each, and drives a 32-bit XGMII transmit word with one control bit per byte lane. The first byte of every frame is the first preamble octet. The block replaces it with the start control character, which always sits on lane 0. It places a terminate control character right after the last valid byte. It then fills the following lanes and words with idle characters until the next frame may begin.

The gap between frames is at least 12 bytes. The terminate character counts toward the gap; the start character does not. Frame lengths that are not a multiple of four leave the terminate on lane 1, 2 or 3. In that case the gap must be rounded so that the next start falls on lane 0. With deficit idle counting off, the block always rounds up. With it on, a small saturating deficit counter lets the block round down, trimming up to three idle bytes. It pays them back later, so the long-run average gap stays at 12 bytes or more.

A build-time option packs two consecutive 32-bit words into one 64-bit output word, qualified by a strobe. The source sees a valid/ready handshake, and ready is held low while the terminate-only word and the gap are emitted.

Top module: `xgmii_tx_gap`

## Requirements
- R1: After reset, and whenever no frame is offered, every output lane carries 0x07 with its control bit set, and ready is high.
- R2: The start character 0xFB with control bit set appears only on lane 0. It replaces byte 0 of the first word of each frame, and lanes 1 to 3 of that word carry the source bytes with control bits clear.
- R3: Frame bytes pass through unchanged with control bits clear. The last word's byte count (1 to 4) selects the terminate lane: count modulo 4, so a count of 4 puts 0xFD on lane 0 of an extra word. All lanes after the terminate, up to the next start, carry 0x07 with control set.
- R4: With deficit counting off, the gap from terminate to next start (terminate included) is 12, 15, 14 or 13 bytes for a terminate lane of 0, 1, 2 or 3.
- R5: With deficit counting on and terminate lane t > 0, the block trims when deficit + t ≤ 3, giving a gap of 12 − t and adding t to the deficit. Otherwise it pads, giving a gap of 16 − t and lowering the deficit by 4 − t, stopping at 0. A terminate on lane 0 gives 12 and leaves the deficit unchanged.
- R6: The deficit is 0 after reset and is forced to 0 while deficit counting is off. After counting is re-enabled, the first decision starts from 0.
- R7: Over any run of frames, the sum of all gaps is at least 12 × (number of gaps) − 3, and no single gap is below 9 bytes.
- R8: Ready is low for exactly the gap words that follow a frame: 2 when the gap is trimmed, 3 when padded, and 3 when the terminate needs its own word. With the next frame waiting, the start follows with no extra word.
- R9: In 64-bit mode the output strobe pulses every second cycle, and each 64-bit word holds two consecutive 32-bit words, the earlier one in bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dicEn | input | 1 | Enables deficit idle counting |
| inValid | input | 1 | Source word valid |
| inReady | output | 1 | Block accepts a word this cycle |
| inData | input | 32 | Source bytes, byte 0 in bits 7:0 |
| inLast | input | 1 | Word is the last of the frame |
| inBytes | input | 3 | Valid bytes in the last word, 1 to 4 |
| xgmiiData | output | 32 × (1 + WIDE_BUS) | Transmit data, lane 0 in the low byte |
| xgmiiCtrl | output | 4 × (1 + WIDE_BUS) | Per-lane control bits |
| xgmiiValid | output | 1 | Output word valid (always high in 32-bit mode) |

## Verification
The bench builds two copies with the default 12-byte minimum gap and a 2-bit deficit: one with a 32-bit output and one with a 64-bit output, both fed the same stream. Frame lengths from 1 to 24 bytes are swept with deficit counting off and then twice with it on. This reaches every terminate lane against every deficit value from 0 to 3, so every trim, pad and saturation case occurs. A final sequence builds up deficit, switches counting off, and re-enables it to expose any deficit that survives the disabled period.

// File: rtl/xgtx_pkg.sv
package xgtx_pkg;

  localparam logic [7:0] IDLE_CH  = 8'h07;
  localparam logic [7:0] START_CH = 8'hFB;
  localparam logic [7:0] TERM_CH  = 8'hFD;

  // Per-cycle instruction from control to the datapath.
  typedef struct packed {
    logic       idleAll;   // whole word idle
    logic       pass;      // copy source bytes
    logic       start;     // replace lane 0 with start character
    logic       termEn;    // terminate on termLane, idle above it
    logic [1:0] termLane;
  } xgtx_strobe_t;

endpackage

// File: rtl/xgtx_ctrl.sv
module xgtx_ctrl
  import xgtx_pkg::*;
#(
  parameter int MIN_GAP = 12,
  parameter int DEF_W   = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dicEn,
  input  logic         inValid,
  input  logic         inLast,
  input  logic [2:0]   inBytes,
  output logic         inReady,
  output xgtx_strobe_t strobe
);

  localparam int LANES     = 4;
  localparam int GAP_WORDS = MIN_GAP / LANES - 1;
  localparam int CNT_W     = $clog2(GAP_WORDS + 2);
  localparam int DEF_MAX   = (1 << DEF_W) - 1;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_TERM, S_GAP} state_t;

  state_t            state, nextState;
  logic [CNT_W-1:0]  gapLeft, nextGap;
  logic [DEF_W-1:0]  deficit, nextDef;

  // Rounding decision for a terminate landing on lane tail.
  logic [1:0]        tail;
  logic [2:0]        padBytes;
  logic [DEF_W+2:0]  defWide, trimSum, padWide;
  logic              trimOk;
  logic [CNT_W-1:0]  decWords;
  logic [DEF_W-1:0]  decDef;

  always_comb begin
    tail     = inBytes[1:0];
    padBytes = 3'(LANES) - {1'b0, tail};
    defWide  = '0;
    defWide[DEF_W-1:0] = deficit;
    padWide  = '0;
    padWide[2:0] = padBytes;
    trimSum  = defWide + {{(DEF_W+1){1'b0}}, tail};
    trimOk   = dicEn && (trimSum <= (DEF_W+3)'(DEF_MAX));
    if (trimOk) begin
      decWords = CNT_W'(GAP_WORDS);
      decDef   = trimSum[DEF_W-1:0];
    end else begin
      decWords = CNT_W'(GAP_WORDS + 1);
      if (dicEn && (defWide > padWide)) decDef = DEF_W'(defWide - padWide);
      else                              decDef = '0;
    end
  end

  always_comb begin
    strobe    = '0;
    inReady   = 1'b0;
    nextState = state;
    nextGap   = gapLeft;
    nextDef   = dicEn ? deficit : '0;
    unique case (state)
      S_IDLE, S_DATA: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.pass  = 1'b1;
          strobe.start = (state == S_IDLE);
          if (!inLast) begin
            nextState = S_DATA;
          end else if (tail == 2'd0) begin
            nextState = S_TERM;
          end else begin
            strobe.termEn   = 1'b1;
            strobe.termLane = tail;
            nextGap         = decWords;
            nextDef         = decDef;
            nextState       = S_GAP;
          end
        end else begin
          strobe.idleAll = 1'b1;
        end
      end
      S_TERM: begin
        strobe.termEn   = 1'b1;
        strobe.termLane = 2'd0;
        nextGap         = CNT_W'(GAP_WORDS);
        nextState       = S_GAP;
      end
      default: begin
        strobe.idleAll = 1'b1;
        nextGap        = gapLeft - 1'b1;
        if (gapLeft == CNT_W'(1)) nextState = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      gapLeft <= '0;
      deficit <= '0;
    end else begin
      state   <= nextState;
      gapLeft <= nextGap;
      deficit <= nextDef;
    end
  end

  // R6: a disabled cycle leaves no deficit behind
  p_dic_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dicEn |=> (deficit == '0));

  // R8: the gap is never cut short and the source stays stalled
  p_gap_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP && gapLeft > CNT_W'(1)) |=> (state == S_GAP && !inReady));

endmodule

// File: rtl/xgtx_datapath.sv
module xgtx_datapath
  import xgtx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  xgtx_strobe_t strobe,
  input  logic [31:0]  inData,
  output logic [31:0]  outData,
  output logic [3:0]   outCtrl
);

  localparam int LANES = 4;

  logic [31:0] nextData;
  logic [3:0]  nextCtrl;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      nextData[8*g +: 8] = IDLE_CH;
      nextCtrl[g]        = 1'b1;
      if (strobe.pass) begin
        nextData[8*g +: 8] = inData[8*g +: 8];
        nextCtrl[g]        = 1'b0;
      end
      if (strobe.start && g == 0) begin
        nextData[8*g +: 8] = START_CH;
        nextCtrl[g]        = 1'b1;
      end
      if (strobe.termEn) begin
        if (g == int'(strobe.termLane)) begin
          nextData[8*g +: 8] = TERM_CH;
          nextCtrl[g]        = 1'b1;
        end else if (g > int'(strobe.termLane)) begin
          nextData[8*g +: 8] = IDLE_CH;
          nextCtrl[g]        = 1'b1;
        end
      end
      if (strobe.idleAll) begin
        nextData[8*g +: 8] = IDLE_CH;
        nextCtrl[g]        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData <= {LANES{IDLE_CH}};
      outCtrl <= '1;
    end else begin
      outData <= nextData;
      outCtrl <= nextCtrl;
    end
  end

  logic hasTerm;
  always_comb begin
    hasTerm = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (outCtrl[i] && outData[8*i +: 8] == TERM_CH) hasTerm = 1'b1;
  end

  for (genvar g = 1; g < LANES; g++) begin : g_chk
    // R2: start character never leaves lane 0
    p_start_lane0_r2: assert property (@(posedge clk) disable iff (!rstN)
      !(outCtrl[g] && outData[8*g +: 8] == START_CH));
  end

  // R3: a terminate word is followed by an all-idle word
  p_idle_after_term_r3: assert property (@(posedge clk) disable iff (!rstN)
    hasTerm |=> (outCtrl == 4'hF && outData == {LANES{IDLE_CH}}));

endmodule

// File: rtl/xgtx_widen.sv
module xgtx_widen (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] inData,
  input  logic [3:0]  inCtrl,
  output logic [63:0] outData,
  output logic [7:0]  outCtrl,
  output logic        outValid
);

  logic        phase;
  logic [31:0] loData;
  logic [3:0]  loCtrl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= 1'b0;
      loData   <= '0;
      loCtrl   <= '0;
      outData  <= '0;
      outCtrl  <= '0;
      outValid <= 1'b0;
    end else begin
      phase    <= ~phase;
      outValid <= phase;
      if (!phase) begin
        loData <= inData;
        loCtrl <= inCtrl;
      end else begin
        outData <= {inData, loData};
        outCtrl <= {inCtrl, loCtrl};
      end
    end
  end

  // R9: one wide word per two narrow words
  p_strobe_alt_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

endmodule

// File: rtl/xgmii_tx_gap.sv
module xgmii_tx_gap
  import xgtx_pkg::*;
#(
  parameter int MIN_GAP  = 12,
  parameter int DEF_W    = 2,
  parameter bit WIDE_BUS = 1'b0,
  localparam int OUT_WORDS = WIDE_BUS ? 2 : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dicEn,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [31:0]            inData,
  input  logic                   inLast,
  input  logic [2:0]             inBytes,
  output logic [32*OUT_WORDS-1:0] xgmiiData,
  output logic [4*OUT_WORDS-1:0]  xgmiiCtrl,
  output logic                   xgmiiValid
);

  xgtx_strobe_t strobe;
  logic [31:0]  coreData;
  logic [3:0]   coreCtrl;

  xgtx_ctrl #(.MIN_GAP(MIN_GAP), .DEF_W(DEF_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .dicEn(dicEn), .inValid(inValid),
    .inLast(inLast), .inBytes(inBytes), .inReady(inReady), .strobe(strobe)
  );

  xgtx_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .outData(coreData), .outCtrl(coreCtrl)
  );

  if (WIDE_BUS) begin : g_wide
    xgtx_widen widen_i (
      .clk(clk), .rstN(rstN), .inData(coreData), .inCtrl(coreCtrl),
      .outData(xgmiiData), .outCtrl(xgmiiCtrl), .outValid(xgmiiValid)
    );
  end else begin : g_narrow
    assign xgmiiData  = coreData;
    assign xgmiiCtrl  = coreCtrl;
    assign xgmiiValid = 1'b1;
  end

endmodule

// File: tb/xgmii_tx_gap_tb_top.sv
module xgmii_tx_gap_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dicEn = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inData = '0;
  logic inLast = 1'b0;
  logic [2:0] inBytes = 3'd4;
  logic inReady, inReady64;
  logic [31:0] xd;
  logic [3:0]  xc;
  logic        xv;
  logic [63:0] xd64;
  logic [7:0]  xc64;
  logic        xv64;

  always #(CLK_PERIOD/2) clk = ~clk;

  xgmii_tx_gap dut_i (
    .clk(clk), .rstN(rstN), .dicEn(dicEn), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .inBytes(inBytes),
    .xgmiiData(xd), .xgmiiCtrl(xc), .xgmiiValid(xv)
  );

  xgmii_tx_gap #(.WIDE_BUS(1'b1)) dut64_i (
    .clk(clk), .rstN(rstN), .dicEn(dicEn), .inValid(inValid), .inReady(inReady64),
    .inData(inData), .inLast(inLast), .inBytes(inBytes),
    .xgmiiData(xd64), .xgmiiCtrl(xc64), .xgmiiValid(xv64)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] expBytes [0:4095];
  int wrPtr = 0, rdPtr = 0;
  int expGap [0:255];
  string expTag [0:255];
  int frameIdx = 0;
  int expWait = 0;
  int mdef = 0;
  logic [7:0] seq = 8'h10;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic sendFrame(input int nBytes, input bit dic, input string tag);
    int nWords, gap, t, waited;
    string gtag;
    nWords = (nBytes + 3) / 4;
    for (int w = 0; w < nWords; w++) begin
      logic [31:0] word;
      bit last;
      word = '0;
      for (int l = 0; l < 4; l++) begin
        int idx;
        idx = 4*w + l;
        if (idx < nBytes) begin
          word[8*l +: 8] = seq;
          if (idx != 0) begin
            expBytes[wrPtr] = seq;
            wrPtr++;
          end
          seq = seq + 8'd1;
        end
      end
      last = (w == nWords - 1);
      @(negedge clk);
      if (w == 0) begin
        dicEn = dic;
        if (!dic) mdef = 0;
      end
      inValid = 1'b1;
      inData  = word;
      inLast  = last;
      inBytes = last ? 3'(nBytes - 4*w) : 3'd4;
      waited  = 0;
      while (!inReady) begin
        waited++;
        @(negedge clk);
      end
      // R8: stall length before the next start
      if (w == 0 && frameIdx > 0)
        check(waited == expWait, "R8", "ready-low words", waited, expWait);
      if (last) begin
        t = nBytes % 4;
        gtag = (tag != "") ? tag : (dic ? "R5" : "R4");
        if (t == 0) begin
          gap = 12;
          expWait = 3;
        end else if (dic && (mdef + t <= 3)) begin
          gap = 12 - t;
          mdef = mdef + t;
          expWait = 2;
        end else begin
          gap = 16 - t;
          mdef = dic ? ((mdef > 4 - t) ? mdef - (4 - t) : 0) : 0;
          expWait = 3;
        end
        expGap[frameIdx] = gap;
        expTag[frameIdx] = gtag;
      end
      @(posedge clk);
    end
    frameIdx++;
  endtask

  // Output monitor
  bit inGap = 0;
  int gapCnt = 0;
  int monFrame = 0;
  int sumGap = 0, nGap = 0;
  logic [31:0] w1d = 32'h07070707, w2d = 32'h07070707;
  logic [3:0]  w1c = 4'hF, w2c = 4'hF;

  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 4; i++) begin
        logic [7:0] b;
        b = xd[8*i +: 8];
        if (xc[i] && b == 8'hFB) begin
          check(i == 0, "R2", "start lane", i, 0);
          if (inGap && monFrame > 0) begin
            check(gapCnt == expGap[monFrame-1], expTag[monFrame-1], "gap bytes",
                  gapCnt, expGap[monFrame-1]);
            sumGap += gapCnt;
            nGap++;
            check(gapCnt >= 9, "R7", "minimum gap", gapCnt, 9);
            check(sumGap + 3 >= 12*nGap, "R7", "gap sum", sumGap, 12*nGap - 3);
          end
          inGap = 0;
          monFrame++;
        end else if (xc[i] && b == 8'hFD) begin
          inGap = 1;
          gapCnt = 1;
        end else if (inGap) begin
          gapCnt++;
          check(xc[i] && b == 8'h07, "R3", "idle lane in gap", {xc[i], b}, 9'h107);
        end else if (!xc[i]) begin
          check(b == expBytes[rdPtr], "R3", "data byte", b, expBytes[rdPtr]);
          rdPtr++;
        end
      end
      if (xv64) begin
        check(xd64 == {w1d, w2d} && xc64 == {w1c, w2c}, "R9", "wide word low half",
              xd64[31:0], w2d);
      end
      w2d = w1d; w2c = w1c;
      w1d = xd;  w1c = xc;
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      // R1: idle pattern and ready with nothing offered
      check(xd == 32'h07070707 && xc == 4'hF, "R1", "idle word", xd, 32'h07070707);
      check(inReady == 1'b1, "R1", "ready when idle", inReady, 1);
    end
    for (int n = 1; n <= 24; n++) sendFrame(n, 1'b0, "");
    for (int rep = 0; rep < 2; rep++)
      for (int n = 1; n <= 24; n++) sendFrame(n, 1'b1, "");
    // R6: build deficit, disable, re-enable; lane-3 terminate must trim
    sendFrame(5, 1'b1, "");
    sendFrame(9, 1'b1, "");
    sendFrame(8, 1'b0, "");
    sendFrame(7, 1'b1, "R6");
    sendFrame(11, 1'b1, "R6");
    sendFrame(4, 1'b1, "");
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    repeat (20) @(negedge clk);
    check(monFrame == frameIdx, "R2", "frames started", monFrame, frameIdx);
    check(rdPtr == wrPtr, "R3", "bytes delivered", rdPtr, wrPtr);
    check(xd == 32'h07070707 && xc == 4'hF && inReady, "R1", "idle after run", xd,
          32'h07070707);
    done = 1;
    finishRun();
  end

endmodule